// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block takes a trap request from a processor pipeline and performs the state changes of trap entry in one clock edge. A request carries a flag that marks it as an interrupt (asynchronous) or an exception (synchronous), a cause code, the faulting address and the program counter of the trapping instruction. The block holds the current privilege level and the interrupt-enable state of the supervisor and machine levels. It takes the delegation masks and the two handler vector bases as configuration inputs from the surrounding control-register logic.

For each request the block chooses the handling level. A trap is handled at supervisor level only when the hart runs at supervisor or user level and the cause's bit is set in the delegation mask that matches the trap kind. It then writes that level's saved PC, cause word and trap value, stacks and clears that level's interrupt enable, records the previous privilege, switches privilege and presents the handler address. A separate load port lets the surrounding logic set the privilege and the two enable bits, for example after a trap return, which this block does not handle.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After a synchronous active-low reset the privilege is machine (encoding 3). All enable, previous-enable and previous-privilege fields are 0, and all saved PC, cause and trap value registers and the handler PC are 0.
- R2: A trap is handled at supervisor level (privilege encoding 1) when the current privilege is user (0) or supervisor (1) and bit `code` of the selected delegation mask is set. In every other case it is handled at machine level (3), and a trap taken at machine level always stays there. A code of 32 or more is never delegated.
- R3: Interrupts (trap_async=1) select irq_deleg as the delegation mask and exceptions select exc_deleg.
- R4: On supervisor entry, s_pie takes the old s_ie, s_pp takes the old privilege bit 0, and s_ie becomes 0. The machine enable fields are left unchanged.
- R5: On machine entry, m_pie takes the old m_ie, m_pp takes the old privilege, and m_ie becomes 0.
- R6: The cause word written has bit 31 equal to trap_async and the (possibly rewritten) code in its low bits, with zeros between.
- R7: handler_pc equals the target level's vector base with bits 1:0 cleared. When the base's bits 1:0 equal 1 and the trap is an interrupt, code times 4 is added. Base bits 1:0 of 0, 2 or 3, and all exceptions, add nothing.
- R8: The trap value receives trap_addr only for exceptions with code 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other code and for all interrupts it is 0.
- R9: An exception with code 8 (environment call) is rewritten to 8 from user, 9 from supervisor and 11 from machine before delegation and before it is written.
- R10: After entry the privilege equals the target level, and the target level's saved PC holds trap_pc. The other level's saved PC, cause and trap value are unchanged.
- R11: A load pulse with no trap sets privilege, s_ie and m_ie from the load inputs. A privilege encoding of 2 is stored as user. A trap in the same cycle takes priority and the load is dropped.
- R12: In a cycle with neither a trap nor a load, all state and handler_pc hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_async | input | 1 | 1 for interrupt, 0 for exception |
| trap_code | input | CODE_W | Cause code |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| ld_valid | input | 1 | One-cycle state load |
| ld_priv | input | 2 | Privilege to load |
| ld_sie | input | 1 | Supervisor enable to load |
| ld_mie | input | 1 | Machine enable to load |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| s_vec_base | input | XLEN | Supervisor handler base, bits 1:0 = dispatch mode |
| m_vec_base | input | XLEN | Machine handler base, bits 1:0 = dispatch mode |
| cur_priv | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| s_ie | output | 1 | Supervisor interrupt enable |
| s_pie | output | 1 | Supervisor previous enable |
| s_pp | output | 1 | Supervisor previous privilege |
| m_ie | output | 1 | Machine interrupt enable |
| m_pie | output | 1 | Machine previous enable |
| m_pp | output | 2 | Machine previous privilege |
| s_epc | output | XLEN | Supervisor saved PC |
| s_cause | output | XLEN | Supervisor cause word |
| s_tval | output | XLEN | Supervisor trap value |
| m_epc | output | XLEN | Machine saved PC |
| m_cause | output | XLEN | Machine cause word |
| m_tval | output | XLEN | Machine trap value |
| handler_pc | output | XLEN | Address of the handler of the last trap |

## Verification
The assertions take for granted that the trap and load inputs are stable and known at every sampling edge. They also assume the configuration inputs (masks and vector bases) change only in cycles without a trap, so that a value seen one edge after a request belongs to that request. The bench changes every input just after a falling edge, holds each request for exactly one cycle, and reconfigures masks and bases only between requests. All stimulus is directed, so each delegation, mode and cause boundary is reached by a known sequence.

// File: rtl/trap_pkg.sv
// trap_pkg: shared privilege encoding and cause classification for the
// trap entry controller. Assumes 2-bit privilege codes with 2 reserved.
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPV  = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    localparam int unsigned ENV_CALL_CODE = 8;

    // True for exception codes that report the faulting address
    function automatic logic code_keeps_addr(input int unsigned code);
        case (code)
            0, 1, 4, 5, 6, 7, 12, 13, 15: code_keeps_addr = 1'b1;
            default:                      code_keeps_addr = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trap_route.sv
// trap_route: picks the handling level for a trap request, rewrites the
// environment-call code by privilege and decides whether the trap value
// keeps the faulting address. Purely combinational. Assumes CODE_W is
// wide enough to index XLEN mask bits plus one overflow bit.
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input  priv_e              priv,
    input  logic               is_irq,
    input  logic [CODE_W-1:0]  code_in,
    input  logic [XLEN-1:0]    exc_mask,
    input  logic [XLEN-1:0]    irq_mask,
    output logic [CODE_W-1:0]  code_out,
    output logic               go_supv,
    output logic               keep_addr
);
    localparam int IDX_W = $clog2(XLEN);

    logic             env_call;
    logic [XLEN-1:0]  sel_mask;
    logic             in_range;
    logic             mask_hit;

    // Rewrite the environment-call code: 8 + privilege encoding
    always_comb begin
        env_call = !is_irq && (code_in == CODE_W'(ENV_CALL_CODE));
        code_out = env_call ? code_in + CODE_W'(priv) : code_in;
    end

    // Delegation lookup in the mask that matches the trap kind
    always_comb begin
        sel_mask  = is_irq ? irq_mask : exc_mask;
        in_range  = (32'(code_out) < 32'(XLEN));
        mask_hit  = in_range && sel_mask[code_out[IDX_W-1:0]];
        go_supv   = (priv != PRIV_MACH) && mask_hit;
        keep_addr = !is_irq && code_keeps_addr(32'(code_out));
    end

endmodule

// File: rtl/trap_vector.sv
// trap_vector: forms the handler address from a vector base. Bits 1:0 of
// the base select the dispatch mode; mode 1 adds code*4 for interrupts
// only. Combinational; assumes code*4 fits inside XLEN.
module trap_vector #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input  logic [XLEN-1:0]   vec_base,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   target_pc
);
    logic            spread;
    logic [XLEN-1:0] offset;

    // Handler address = aligned base plus optional per-cause slot
    always_comb begin
        spread    = is_irq && (vec_base[1:0] == 2'b01);
        offset    = spread ? XLEN'({code, 2'b00}) : '0;
        target_pc = {vec_base[XLEN-1:2], 2'b00} + offset;
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
// trap_entry_ctrl: applies one trap request per cycle to the privilege,
// enable stacks and per-level saved PC, cause and trap value registers.
// Assumes trap_valid and ld_valid are single-cycle pulses; a trap wins
// over a load in the same cycle. All updates land on the next clock edge.
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic              trap_async,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_addr,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic              ld_valid,
    input  logic [1:0]        ld_priv,
    input  logic              ld_sie,
    input  logic              ld_mie,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    input  logic [XLEN-1:0]   s_vec_base,
    input  logic [XLEN-1:0]   m_vec_base,
    output logic [1:0]        cur_priv,
    output logic              s_ie,
    output logic              s_pie,
    output logic              s_pp,
    output logic              m_ie,
    output logic              m_pie,
    output logic [1:0]        m_pp,
    output logic [XLEN-1:0]   s_epc,
    output logic [XLEN-1:0]   s_cause,
    output logic [XLEN-1:0]   s_tval,
    output logic [XLEN-1:0]   m_epc,
    output logic [XLEN-1:0]   m_cause,
    output logic [XLEN-1:0]   m_tval,
    output logic [XLEN-1:0]   handler_pc
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    priv_e             priv_q;
    logic [CODE_W-1:0] eff_code;
    logic              to_supv;
    logic              keep_addr;
    logic [XLEN-1:0]   cause_word;
    logic [XLEN-1:0]   tval_word;
    logic [XLEN-1:0]   base_sel;
    logic [XLEN-1:0]   next_pc;
    priv_e             ld_priv_fix;

    trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
        .priv      (priv_q),
        .is_irq    (trap_async),
        .code_in   (trap_code),
        .exc_mask  (exc_deleg),
        .irq_mask  (irq_deleg),
        .code_out  (eff_code),
        .go_supv   (to_supv),
        .keep_addr (keep_addr)
    );

    trap_vector #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
        .vec_base  (base_sel),
        .is_irq    (trap_async),
        .code      (eff_code),
        .target_pc (next_pc)
    );

    // Build the cause word, trap value and vector base for the chosen level
    always_comb begin
        cause_word  = {trap_async, {PAD_W{1'b0}}, eff_code};
        tval_word   = keep_addr ? trap_addr : '0;
        base_sel    = to_supv ? s_vec_base : m_vec_base;
        ld_priv_fix = (ld_priv == 2'd2) ? PRIV_USER : priv_e'(ld_priv);
    end

    // Privilege and enable stack: trap entry first, then state load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_MACH;
            s_ie   <= 1'b0;
            s_pie  <= 1'b0;
            s_pp   <= 1'b0;
            m_ie   <= 1'b0;
            m_pie  <= 1'b0;
            m_pp   <= 2'd0;
        end else if (trap_valid) begin
            if (to_supv) begin
                s_pie  <= s_ie;
                s_pp   <= priv_q[0];
                s_ie   <= 1'b0;
                priv_q <= PRIV_SUPV;
            end else begin
                m_pie  <= m_ie;
                m_pp   <= priv_q;
                m_ie   <= 1'b0;
                priv_q <= PRIV_MACH;
            end
        end else if (ld_valid) begin
            priv_q <= ld_priv_fix;
            s_ie   <= ld_sie;
            m_ie   <= ld_mie;
        end
    end

    // Per-level trap record registers and the handler address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_epc      <= '0;
            s_cause    <= '0;
            s_tval     <= '0;
            m_epc      <= '0;
            m_cause    <= '0;
            m_tval     <= '0;
            handler_pc <= '0;
        end else if (trap_valid) begin
            handler_pc <= next_pc;
            if (to_supv) begin
                s_epc   <= trap_pc;
                s_cause <= cause_word;
                s_tval  <= tval_word;
            end else begin
                m_epc   <= trap_pc;
                m_cause <= cause_word;
                m_tval  <= tval_word;
            end
        end
    end

    assign cur_priv = priv_q;

endmodule

// File: rtl/trap_entry_chk.sv
// trap_entry_chk: temporal checks on the trap entry controller ports,
// attached with bind. Assumes inputs are known at each sampling edge.
module trap_entry_chk #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid,
    input logic            trap_async,
    input logic [XLEN-1:0] trap_pc,
    input logic            ld_valid,
    input logic [1:0]      cur_priv,
    input logic            s_ie,
    input logic            m_ie,
    input logic [XLEN-1:0] s_epc,
    input logic [XLEN-1:0] s_cause,
    input logic [XLEN-1:0] s_tval,
    input logic [XLEN-1:0] m_epc,
    input logic [XLEN-1:0] m_cause,
    input logic [XLEN-1:0] m_tval,
    input logic [XLEN-1:0] handler_pc
);
    // R2
    from_mach_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && cur_priv == 2'd3) |=> (cur_priv == 2'd3));

    // R4 R5
    enable_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> ((cur_priv == 2'd1) ? !s_ie : !m_ie));

    // R6
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (((cur_priv == 2'd1) ? s_cause[XLEN-1] : m_cause[XLEN-1])
                        == $past(trap_async)));

    // R10
    saved_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (((cur_priv == 2'd1) ? s_epc : m_epc) == $past(trap_pc)));

    // R7
    handler_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (handler_pc[1:0] == 2'b00));

    // R8
    irq_tval_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_async) |=> (((cur_priv == 2'd1) ? s_tval : m_tval) == '0));

    // R11
    priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_priv != 2'd2);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_valid && !ld_valid) |=> ($stable(cur_priv) && $stable(s_epc) &&
                                        $stable(m_epc) && $stable(handler_pc) &&
                                        $stable(s_cause) && $stable(m_cause)));

endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_valid (trap_valid),
    .trap_async (trap_async),
    .trap_pc    (trap_pc),
    .ld_valid   (ld_valid),
    .cur_priv   (cur_priv),
    .s_ie       (s_ie),
    .m_ie       (m_ie),
    .s_epc      (s_epc),
    .s_cause    (s_cause),
    .s_tval     (s_tval),
    .m_epc      (m_epc),
    .m_cause    (m_cause),
    .m_tval     (m_tval),
    .handler_pc (handler_pc)
);

// File: tb/trap_entry_ctrl_tb.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb;
    localparam int XLEN   = 32;
    localparam int CODE_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_valid = 1'b0;
    logic              trap_async = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [XLEN-1:0]   trap_addr = '0;
    logic [XLEN-1:0]   trap_pc = '0;
    logic              ld_valid = 1'b0;
    logic [1:0]        ld_priv = '0;
    logic              ld_sie = 1'b0;
    logic              ld_mie = 1'b0;
    logic [XLEN-1:0]   exc_deleg = 32'h0000_2100;
    logic [XLEN-1:0]   irq_deleg = 32'h0000_0220;
    logic [XLEN-1:0]   s_vec_base = 32'h4000_0001;
    logic [XLEN-1:0]   m_vec_base = 32'h8000_0001;
    logic [1:0]        cur_priv;
    logic              s_ie, s_pie, s_pp, m_ie, m_pie;
    logic [1:0]        m_pp;
    logic [XLEN-1:0]   s_epc, s_cause, s_tval, m_epc, m_cause, m_tval, handler_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_async(trap_async),
        .trap_code(trap_code), .trap_addr(trap_addr), .trap_pc(trap_pc),
        .ld_valid(ld_valid), .ld_priv(ld_priv), .ld_sie(ld_sie), .ld_mie(ld_mie),
        .exc_deleg(exc_deleg), .irq_deleg(irq_deleg),
        .s_vec_base(s_vec_base), .m_vec_base(m_vec_base),
        .cur_priv(cur_priv), .s_ie(s_ie), .s_pie(s_pie), .s_pp(s_pp),
        .m_ie(m_ie), .m_pie(m_pie), .m_pp(m_pp),
        .s_epc(s_epc), .s_cause(s_cause), .s_tval(s_tval),
        .m_epc(m_epc), .m_cause(m_cause), .m_tval(m_tval), .handler_pc(handler_pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // State load pulse; outputs valid after the following falling edge
    task automatic load_state(input logic [1:0] p, input logic si, input logic mi);
        @(negedge clk);
        ld_valid = 1'b1; ld_priv = p; ld_sie = si; ld_mie = mi;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Trap pulse, optionally with a competing load in the same cycle
    task automatic fire(input logic a, input int c, input logic [31:0] addr,
                        input logic [31:0] pc, input logic with_ld);
        @(negedge clk);
        trap_valid = 1'b1; trap_async = a; trap_code = CODE_W'(c);
        trap_addr = addr; trap_pc = pc;
        ld_valid = with_ld; ld_priv = 2'd0; ld_sie = 1'b1; ld_mie = 1'b1;
        @(negedge clk);
        trap_valid = 1'b0; ld_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 priv", 32'(cur_priv), 32'd3);
        chk("R1 m_cause", m_cause, 32'd0);
        chk("R1 s_cause", s_cause, 32'd0);
        chk("R1 handler_pc", handler_pc, 32'd0);
        chk("R1 enables", {27'd0, s_ie, s_pie, s_pp, m_ie, m_pie}, 32'd0);
        chk("R1 m_pp", 32'(m_pp), 32'd0);
    endtask

    task automatic t_ecall_mach();
        load_state(2'd3, 1'b0, 1'b1);
        fire(1'b0, 8, 32'h77, 32'h100, 1'b0);
        chk("R9 ecall from M", m_cause, 32'd11);
        chk("R10 m_epc", m_epc, 32'h100);
        chk("R8 tval zero for ecall", m_tval, 32'd0);
        chk("R5 m_pie", 32'(m_pie), 32'd1);
        chk("R5 m_ie", 32'(m_ie), 32'd0);
        chk("R5 m_pp", 32'(m_pp), 32'd3);
        chk("R7 sync ignores vector slot", handler_pc, 32'h8000_0000);
    endtask

    task automatic t_deleg_exc();
        load_state(2'd0, 1'b1, 1'b0);
        fire(1'b0, 13, 32'hDEAD_BEEF, 32'h2000, 1'b0);
        chk("R2 delegated cause", s_cause, 32'd13);
        chk("R8 s_tval addr", s_tval, 32'hDEAD_BEEF);
        chk("R10 s_epc", s_epc, 32'h2000);
        chk("R10 priv S", 32'(cur_priv), 32'd1);
        chk("R4 s_pp", 32'(s_pp), 32'd0);
        chk("R4 s_pie", 32'(s_pie), 32'd1);
        chk("R4 s_ie", 32'(s_ie), 32'd0);
        chk("R4 m_pie untouched", 32'(m_pie), 32'd1);
        chk("R10 m_cause untouched", m_cause, 32'd11);
        chk("R7 s handler", handler_pc, 32'h4000_0000);
    endtask

    task automatic t_undeleg_from_s();
        load_state(2'd1, 1'b0, 1'b1);
        fire(1'b0, 2, 32'h55, 32'h2400, 1'b0);
        chk("R2 not delegated", m_cause, 32'd2);
        chk("R8 tval zero code 2", m_tval, 32'd0);
        chk("R5 m_pp from S", 32'(m_pp), 32'd1);
        chk("R10 s_cause untouched", s_cause, 32'd13);
        chk("R10 priv M", 32'(cur_priv), 32'd3);
    endtask

    task automatic t_vectored_irq();
        load_state(2'd0, 1'b1, 1'b1);
        fire(1'b1, 5, 32'h1234, 32'h3000, 1'b0);
        chk("R6 irq cause", s_cause, 32'h8000_0005);
        chk("R7 vectored S", handler_pc, 32'h4000_0014);
        chk("R8 irq tval zero", s_tval, 32'd0);
        load_state(2'd0, 1'b0, 1'b1);
        fire(1'b1, 13, 32'h0, 32'h3100, 1'b0);
        chk("R3 irq mask used", m_cause, 32'h8000_000D);
        chk("R7 vectored M", handler_pc, 32'h8000_0034);
        chk("R5 m_pp from U", 32'(m_pp), 32'd0);
    endtask

    task automatic t_mask_select();
        load_state(2'd0, 1'b0, 1'b0);
        fire(1'b0, 5, 32'hABCD_0000, 32'h3200, 1'b0);
        chk("R3 exc mask used", m_cause, 32'd5);
        chk("R8 access fault tval", m_tval, 32'hABCD_0000);
    endtask

    task automatic t_direct_modes();
        for (int md = 0; md < 4; md++) begin
            if (md == 1) continue;
            m_vec_base = 32'h8000_0000 | 32'(md);
            load_state(2'd3, 1'b0, 1'b0);
            fire(1'b1, 7, 32'h0, 32'h3300, 1'b0);
            chk("R7 non-vectored mode", handler_pc, 32'h8000_0000);
        end
        m_vec_base = 32'h8000_0001;
    endtask

    task automatic t_high_cause();
        irq_deleg = 32'hFFFF_FFFF;
        load_state(2'd0, 1'b0, 1'b0);
        fire(1'b1, 40, 32'h0, 32'h3400, 1'b0);
        chk("R2 code 40 not delegated", m_cause, 32'h8000_0028);
        chk("R7 vector slot 40", handler_pc, 32'h8000_00A0);
        load_state(2'd0, 1'b0, 1'b0);
        fire(1'b1, 31, 32'h0, 32'h3500, 1'b0);
        chk("R2 code 31 delegated", s_cause, 32'h8000_001F);
        chk("R7 vector slot 31", handler_pc, 32'h4000_007C);
        irq_deleg = 32'h0000_0220;
    endtask

    task automatic t_ecall_modes();
        load_state(2'd0, 1'b0, 1'b0);
        fire(1'b0, 8, 32'h9, 32'h3600, 1'b0);
        chk("R9 ecall from U", s_cause, 32'd8);
        fire(1'b0, 8, 32'h9, 32'h3700, 1'b0);
        chk("R9 ecall from S", m_cause, 32'd9);
        exc_deleg = 32'hFFFF_FFFF;
        fire(1'b0, 8, 32'h9, 32'h3800, 1'b0);
        chk("R9 ecall from M", m_cause, 32'd11);
        chk("R2 M never delegates", 32'(cur_priv), 32'd3);
        exc_deleg = 32'h0000_2100;
    endtask

    task automatic t_load_rules();
        load_state(2'd2, 1'b1, 1'b0);
        chk("R11 reserved priv to U", 32'(cur_priv), 32'd0);
        chk("R11 load s_ie", 32'(s_ie), 32'd1);
        fire(1'b0, 2, 32'h0, 32'h3900, 1'b1);
        chk("R11 trap beats load priv", 32'(cur_priv), 32'd3);
        chk("R11 trap beats load m_ie", 32'(m_ie), 32'd0);
        chk("R11 trap record", m_epc, 32'h3900);
    endtask

    task automatic t_idle_hold();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            trap_pc = 32'h5000 + 32'(k); trap_code = CODE_W'(k); trap_async = k[0];
        end
        @(negedge clk);
        chk("R12 m_epc held", m_epc, 32'h3900);
        chk("R12 priv held", 32'(cur_priv), 32'd3);
        chk("R12 handler held", handler_pc, 32'h8000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ecall_mach();
        t_deleg_exc();
        t_undeleg_from_s();
        t_vectored_irq();
        t_mask_select();
        t_direct_modes();
        t_high_cause();
        t_ecall_modes();
        t_load_rules();
        t_idle_hold();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule